// File: doc/BRIEF.md
# Packed Signed 16-bit Multiplier with Pair-Sum Mode

The block multiplies two 64-bit operands lane by lane. Each operand holds four signed 16-bit words, and the words in matching lanes are multiplied in parallel to form four 32-bit two's-complement products. An operation code, captured together with the operands, selects one of three results:

- the upper half of every product, one 16-bit result per lane;
- the lower half of every product, one 16-bit result per lane;
- the four products summed in neighbouring pairs, giving two 32-bit results.

The pair-sum mode does not accumulate. A later, separate add joins its result with a running total.

Operands are offered with a valid flag against a ready flag that is always high, so one operation can enter on every clock. Each operation's code travels down the pipeline beside its data. With default parameters the result register shows an operation's result two cycles after the operation is accepted, and a result-valid flag marks it. Between results, the result register keeps its last value.

Top module: `pkmul_unit`

## Requirements
- R1: While rst_n is low, out_valid is 0 and out_data is all zeros.
- R2: in_ready is 1 in every cycle after reset.
- R3: With in_op = 0 (high half), lane i of out_data (bits 16i+15..16i) equals bits 31..16 of the signed product of lane i of in_a and lane i of in_b. A zero operand in a lane gives 0000h in that lane.
- R4: With in_op = 1 (low half), lane i of out_data equals bits 15..0 of the signed product of lane i of in_a and lane i of in_b.
- R5: With in_op = 2 (pair sum), out_data[31:0] is the sum of the lane 0 and lane 1 products, and out_data[63:32] is the sum of the lane 2 and lane 3 products. Each sum wraps in 32 bits, so operands that are all 8000h give 80000000h in both halves.
- R6: With in_op = 3 (unused code), the result is all zeros and out_valid is still raised.
- R7: An operation accepted (in_valid high) in cycle n raises out_valid in cycle n+2 and in no other cycle. Back-to-back operations produce back-to-back results.
- R8: In a cycle where out_valid is low, out_data keeps the value it last held. Operands and codes driven while in_valid is low have no effect on out_data.
- R9: Each operation's result is formed with its own code, even when consecutive operations in the pipeline use different codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and code offered this cycle |
| in_ready | output | 1 | Block can take an operation (always 1) |
| in_op | input | 2 | Operation code: 0 high half, 1 low half, 2 pair sum, 3 zero |
| in_a | input | 64 | First operand, four signed 16-bit lanes, lane 0 in the low bits |
| in_b | input | 64 | Second operand, same layout |
| out_valid | output | 1 | out_data holds a new result this cycle |
| out_data | output | 64 | Registered result |

## Verification
Inputs are driven on the falling edge, so an operation driven in cycle n is taken at the rising edge that ends cycle n. The product register loads at that edge, and the result register loads at the next one. The result is then due in cycle n+2, and the bench compares it at the falling edge of that cycle. The bench keeps a two-entry history of what it offered and compares out_valid with the entry from two steps earlier. When that entry was valid, out_data must equal the expected value computed from that entry's own code and operands. Otherwise out_data must equal the last result. This history makes every code change in the random mix and every idle gap fall due at a known cycle.

// File: rtl/pkmul_pkg.sv
package pkmul_pkg;

   localparam int OP_W = 2;

   typedef enum logic [OP_W-1:0] {
      PM_HIGH    = 2'd0,
      PM_LOW     = 2'd1,
      PM_PAIRSUM = 2'd2,
      PM_NONE    = 2'd3
   } pm_op_e;

endpackage

// File: rtl/pkmul_lane.sv
module pkmul_lane #(
   parameter int W        = 16,
   parameter bit PROD_REG = 1'b1,
   localparam int PW      = 2 * W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic signed [W-1:0]  a,
   input  logic signed [W-1:0]  b,
   output logic        [PW-1:0] prod
);

   logic signed [PW-1:0] full;

   always_comb begin
      full = PW'(a) * PW'(b);
   end

   generate
      if (PROD_REG) begin : g_reg
         logic [PW-1:0] prod_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prod_q <= '0;
            end else if (en) begin
               prod_q <= full;
            end
         end

         assign prod = prod_q;

         // R3: a zero operand in a lane yields a zero product one edge later
         a_r3_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
            (en && (a == '0 || b == '0)) |=> (prod == '0));
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n ^ en;
         assign prod = full;
      end
   endgenerate

endmodule

// File: rtl/pkmul_combine.sv
module pkmul_combine
   import pkmul_pkg::*;
#(
   parameter int LANE_W = 16,
   parameter int LANES  = 4,
   localparam int PW    = 2 * LANE_W,
   localparam int DW    = LANES * LANE_W,
   localparam int PAIRS = LANES / 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  pm_op_e                      in_op,
   input  logic [LANES-1:0][PW-1:0]    in_prod,
   output logic                        out_valid,
   output logic [DW-1:0]               out_data
);

   logic [DW-1:0] hi_vec;
   logic [DW-1:0] lo_vec;
   logic [DW-1:0] sum_vec;
   logic [DW-1:0] nxt;

   genvar gi;
   generate
      for (gi = 0; gi < LANES; gi++) begin : g_half
         assign hi_vec[gi*LANE_W +: LANE_W] = in_prod[gi][PW-1:LANE_W];
         assign lo_vec[gi*LANE_W +: LANE_W] = in_prod[gi][LANE_W-1:0];
      end
      for (gi = 0; gi < PAIRS; gi++) begin : g_pair
         assign sum_vec[gi*PW +: PW] = in_prod[2*gi] + in_prod[2*gi+1];
      end
   endgenerate

   always_comb begin
      unique case (in_op)
         PM_HIGH:    nxt = hi_vec;
         PM_LOW:     nxt = lo_vec;
         PM_PAIRSUM: nxt = sum_vec;
         default:    nxt = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data <= nxt;
         end
      end
   end

   // R6: the unused code produces a valid, all-zero result
   a_r6_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == PM_NONE) |=> (out_valid && out_data == '0));

endmodule

// File: rtl/pkmul_unit.sv
module pkmul_unit
   import pkmul_pkg::*;
#(
   parameter int LANE_W   = 16,
   parameter int LANES    = 4,
   parameter bit PROD_REG = 1'b1,
   localparam int PW      = 2 * LANE_W,
   localparam int DW      = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [OP_W-1:0]   in_op,
   input  logic [DW-1:0]     in_a,
   input  logic [DW-1:0]     in_b,
   output logic              out_valid,
   output logic [DW-1:0]     out_data
);

   generate
      if (LANES < 2 || (LANES % 2) != 0) begin : g_chk_lanes
         $error("pkmul_unit: LANES must be even and at least 2");
      end
      if (LANE_W < 2) begin : g_chk_width
         $error("pkmul_unit: LANE_W must be at least 2");
      end
   endgenerate

   assign in_ready = 1'b1;

   logic                     take;
   logic [LANES-1:0][PW-1:0] prod;
   logic                     s1_valid;
   pm_op_e                   s1_op;

   assign take = in_valid & in_ready;

   genvar gl;
   generate
      for (gl = 0; gl < LANES; gl++) begin : g_lane
         pkmul_lane #(
            .W        (LANE_W),
            .PROD_REG (PROD_REG)
         ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (take),
            .a     (in_a[gl*LANE_W +: LANE_W]),
            .b     (in_b[gl*LANE_W +: LANE_W]),
            .prod  (prod[gl])
         );
      end

      if (PROD_REG) begin : g_tag_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s1_valid <= 1'b0;
               s1_op    <= PM_HIGH;
            end else begin
               s1_valid <= take;
               if (take) begin
                  s1_op <= pm_op_e'(in_op);
               end
            end
         end

         // R7: accepted operation shows up exactly two edges later
         a_r7_valid_due: assert property (@(posedge clk) disable iff (!rst_n)
            take |-> ##2 out_valid);
         a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            !take |-> ##2 !out_valid);
      end else begin : g_tag_comb
         assign s1_valid = take;
         assign s1_op    = pm_op_e'(in_op);

         a_r7_valid_due: assert property (@(posedge clk) disable iff (!rst_n)
            take |=> out_valid);
      end
   endgenerate

   pkmul_combine #(
      .LANE_W (LANE_W),
      .LANES  (LANES)
   ) u_comb (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (s1_valid),
      .in_op     (s1_op),
      .in_prod   (prod),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   // R1: reset clears the result side
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && out_data == '0));

   // R8: no new result means the result register keeps its value
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_data));

endmodule

// File: tb/sim_pkmul_unit.sv
module sim_pkmul_unit;

   logic        clk;
   logic        rst_n;
   logic        in_valid;
   logic        in_ready;
   logic [1:0]  in_op;
   logic [63:0] in_a;
   logic [63:0] in_b;
   logic        out_valid;
   logic [63:0] out_data;

   int total;
   int bad;
   bit done;

   logic        pv1_v, pv2_v;
   logic [63:0] pv1_d, pv2_d;
   logic [1:0]  pv1_op, pv2_op;
   logic [63:0] last_d;
   string       phase;

   pkmul_unit u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_op     (in_op),
      .in_a      (in_a),
      .in_b      (in_b),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   function automatic logic [63:0] model(input logic [1:0] op,
                                         input logic [63:0] a,
                                         input logic [63:0] b);
      logic [3:0][31:0] p;
      logic [63:0]      r;
      for (int i = 0; i < 4; i++) begin
         p[i] = 32'($signed(a[i*16 +: 16])) * 32'($signed(b[i*16 +: 16]));
      end
      r = '0;
      case (op)
         2'd0: for (int i = 0; i < 4; i++) r[i*16 +: 16] = p[i][31:16];
         2'd1: for (int i = 0; i < 4; i++) r[i*16 +: 16] = p[i][15:0];
         2'd2: begin
            r[31:0]  = p[0] + p[1];
            r[63:32] = p[2] + p[3];
         end
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic string optag(input logic [1:0] op);
      case (op)
         2'd0: return "R3";
         2'd1: return "R4";
         2'd2: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s [%s] got=%h exp=%h", tag, phase, got, exp);
      end
   endtask

   task automatic step(input logic v, input logic [1:0] op,
                       input logic [63:0] a, input logic [63:0] b);
      @(negedge clk);
      chk(in_ready == 1'b1, "R2", 64'(in_ready), 64'd1);
      chk(out_valid == pv2_v, "R7", 64'(out_valid), 64'(pv2_v));
      if (pv2_v) begin
         chk(out_data == pv2_d, optag(pv2_op), out_data, pv2_d);
         last_d = pv2_d;
      end else begin
         chk(out_data == last_d, "R8", out_data, last_d);
      end
      pv2_v  = pv1_v;
      pv2_d  = pv1_d;
      pv2_op = pv1_op;
      pv1_v  = v;
      pv1_op = op;
      pv1_d  = model(op, a, b);
      in_valid = v;
      in_op    = op;
      in_a     = a;
      in_b     = b;
   endtask

   function automatic logic [63:0] rnd64();
      return {$urandom(), $urandom()};
   endfunction

   initial begin
      total = 0;
      bad = 0;
      done = 1'b0;
      void'($urandom(32'h5eed_0042));
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_op    = 2'd0;
      in_a     = '0;
      in_b     = '0;
      pv1_v = 0; pv2_v = 0; pv1_d = '0; pv2_d = '0; pv1_op = 0; pv2_op = 0;
      last_d = '0;
      phase = "reset";
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1", 64'(out_valid), 64'd0);
      chk(out_data == '0, "R1", out_data, 64'd0);
      rst_n = 1'b1;

      phase = "directed";
      for (int op = 0; op < 4; op++) begin
         step(1, 2'(op), {4{16'h8000}}, {4{16'h8000}});
      end
      step(1, 2'd2, {4{16'h7fff}}, {4{16'h7fff}});
      step(1, 2'd0, {4{16'hffff}}, {4{16'hffff}});
      step(1, 2'd1, 64'h8000_7fff_ffff_0001, 64'h7fff_8000_0002_ffff);
      step(1, 2'd0, 64'h0000_1234_0000_8000, 64'h5678_0000_ffff_0000);
      step(1, 2'd2, 64'h8000_8000_7fff_8000, 64'h8000_8000_8000_7fff);

      phase = "R8 idle gap";
      for (int i = 0; i < 6; i++) begin
         step(0, 2'($urandom()), rnd64(), rnd64());
      end

      phase = "R9 random mix";
      for (int i = 0; i < 600; i++) begin
         step(($urandom() % 4) != 0, 2'($urandom()), rnd64(), rnd64());
      end

      phase = "R9 back to back";
      for (int i = 0; i < 40; i++) begin
         step(1, 2'(i % 4), rnd64(), rnd64());
      end

      phase = "drain";
      step(0, 2'd0, '0, '0);
      step(0, 2'd0, '0, '0);
      step(0, 2'd0, '0, '0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog R7 got=%h exp=%h", 64'd0, 64'd1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule